// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block holds the write-protection state of every erase block in a flash array and changes those states on command. Each block is in exactly one of three states: lock-tight, locked or unlocked. Lock-tight is sticky: once a block is lock-tight, no command handled here can change it, and only a reset releases it. A register interface sets a first and a last block index. A command then walks that range, or the whole array for unlock-all, one block per clock, and applies the requested change.

The walk of an unlock or lock command stops at the first lock-tight block it meets. A lock-tight command skips blocks that are unlocked and keeps walking. A walk that reaches an index past the last real block raises a command-error flag and stops. Each block that a walk rewrites also copies its new state into a write-protection status word. A combinational query port lets a program or erase engine ask whether a given block may be modified.

Commands arrive on a valid/ready handshake. `cmd_ready` is high exactly when no walk is running. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a walk runs, `cmd_ready` is low and any command offered is dropped, not queued, so back-pressure never holds data for later. The range registers and the query port are plain control pins without a handshake.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset, every block reads locked, `wp_status` is 0x0002, `busy` and `cmd_err` are low, `cmd_ready` is high and both range registers are 0.
- R2: `qry_state` shows the addressed block's state one-hot (bit 0 lock-tight, bit 1 locked, bit 2 unlocked), and `qry_writable` is high only when that block is unlocked.
- R3: A write with `reg_wr_sel`=0 loads the first-block register and also the last-block register with `reg_wr_data` masked to its low IDX_W bits (IDX_W = 4 by default, so 0x37 gives 7).
- R4: A write with `reg_wr_sel`=1 loads only the last-block register, masked the same way, and leaves the first-block register unchanged.
- R5: Code 0x23 unlocks and code 0x2a locks each block from first to last inclusive. The walk ends at the first lock-tight block, which is left unchanged along with every block after it.
- R6: Code 0x2c walks the same range. It leaves unlocked blocks unchanged, keeps going, and makes every other block lock-tight. A lock-tight block never changes state until reset.
- R7: Code 0x27 unlocks blocks from 0 to NUM_BLOCKS-1 and uses the same stop rule at a lock-tight block as 0x23.
- R8: When the walk reaches an index at or above NUM_BLOCKS, `cmd_err` is set and the walk ends. `cmd_err` is cleared when the next command is accepted.
- R9: Each block that a walk rewrites puts its new one-hot state into `wp_status[2:0]`. `wp_status` keeps its value in every other cycle, and bits 15:3 stay 0.
- R10: A walk handles one block per cycle. `done` is a one-cycle pulse N cycles after the accepting edge, where N is the number of blocks visited (at least 1). `busy` is high from the accepting edge until `done`. Commands offered while busy are ignored.
- R11: A range whose first block is above its last block, or an unrecognised code, changes no block and no status, and `done` comes after 1 cycle with `cmd_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (cold reset) |
| reg_wr_en | input | 1 | Range register write strobe |
| reg_wr_sel | input | 1 | 0 = first-block register (also loads last), 1 = last-block register |
| reg_wr_data | input | 16 | Register write value |
| start_blk | output | IDX_W | First-block register |
| end_blk | output | IDX_W | Last-block register |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_code | input | 8 | Command code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| cmd_err | output | 1 | Command error (out-of-range index) |
| wp_status | output | 16 | Write-protection status word |
| qry_blk | input | IDX_W | Block index to query |
| qry_state | output | 3 | One-hot state of the queried block |
| qry_writable | output | 1 | Queried block may be modified |

## Verification
A register write is visible on `start_blk`/`end_blk` one edge after the strobe, so the bench drives on the falling edge and reads on the next falling edge. After a command is taken, `done` is due after exactly N rising edges, where N is the number of blocks visited including the block that stops the walk. The bench counts falling edges from acceptance until `done` and compares that count with N from its own model, then checks that `done` is low one cycle later. Block states, `wp_status` and `cmd_err` are read after `done`, when they are settled. The query port is combinational, so each block is read one step after `qry_blk` changes.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef logic [2:0] blk_st_t;

  // one-hot block states; the bit positions are visible on qry_state / wp_status
  localparam blk_st_t ST_TIGHT    = 3'b001;
  localparam blk_st_t ST_LOCKED   = 3'b010;
  localparam blk_st_t ST_UNLOCKED = 3'b100;

  localparam logic [7:0] CODE_UNLOCK     = 8'h23;
  localparam logic [7:0] CODE_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] CODE_LOCK       = 8'h2a;
  localparam logic [7:0] CODE_TIGHT      = 8'h2c;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_UNLOCK,
    OP_UNLOCK_ALL,
    OP_LOCK,
    OP_TIGHT
  } walk_op_t;

  function automatic walk_op_t decode_op(input logic [7:0] code);
    walk_op_t op;
    unique case (code)
      CODE_UNLOCK:     op = OP_UNLOCK;
      CODE_UNLOCK_ALL: op = OP_UNLOCK_ALL;
      CODE_LOCK:       op = OP_LOCK;
      CODE_TIGHT:      op = OP_TIGHT;
      default:         op = OP_NONE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/flk_range_regs.sv
module flk_range_regs #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  start_o,
  output logic [IDX_W-1:0]  end_o
);

  logic [IDX_W-1:0] start_q, end_q;
  logic [IDX_W-1:0] wr_idx;

  assign wr_idx = wr_data[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        start_q <= wr_idx;
        end_q   <= wr_idx;
      end else begin
        end_q <= wr_idx;
      end
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;

  // R3
  start_twin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (end_q == start_q));

  // R4
  end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(start_q));

endmodule

// File: rtl/flk_state_array.sv
module flk_state_array
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  blk_st_t          wr_st,
  input  logic [IDX_W-1:0] rd_idx,
  output blk_st_t          rd_st,
  input  logic [IDX_W-1:0] qry_idx,
  output blk_st_t          qry_st
);

  blk_st_t blk_q [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               blk_q[g] <= ST_LOCKED;
      else if (wr_en && (int'(wr_idx) == g))    blk_q[g] <= wr_st;
    end

    // R6
    tight_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q[g] == ST_TIGHT) |=> (blk_q[g] == ST_TIGHT));

    // R2
    blk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(blk_q[g]));
  end

  // read muxes; an index past the array reads locked
  always_comb begin
    rd_st  = ST_LOCKED;
    qry_st = ST_LOCKED;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (int'(rd_idx) == i)  rd_st  = blk_q[i];
      if (int'(qry_idx) == i) qry_st = blk_q[i];
    end
  end

endmodule

// File: rtl/flk_walker.sv
module flk_walker
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] first_blk,
  input  logic [IDX_W-1:0] last_blk,
  output logic [IDX_W-1:0] rd_idx,
  input  blk_st_t          rd_st,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output blk_st_t          wr_st,
  output logic             busy,
  output logic             done,
  output logic             err,
  output blk_st_t          wp_st
);

  localparam logic [IDX_W:0]   NB_EXT   = (IDX_W+1)'(NUM_BLOCKS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  typedef enum logic {W_IDLE, W_RUN} wstate_t;

  wstate_t          st_q;
  walk_op_t         op_q, op_in;
  logic [IDX_W-1:0] cur_q, last_q;
  logic             done_q, err_q;
  blk_st_t          wp_q;
  logic             accept, fin, err_set;

  assign cmd_ready = (st_q == W_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign op_in     = decode_op(cmd_code);

  // per-cycle decision for the block under the cursor
  always_comb begin
    fin     = 1'b0;
    err_set = 1'b0;
    wr_en   = 1'b0;
    wr_st   = rd_st;
    if (st_q == W_RUN) begin
      if (op_q == OP_NONE || cur_q > last_q) begin
        fin = 1'b1;
      end else if ({1'b0, cur_q} >= NB_EXT) begin
        err_set = 1'b1;
        fin     = 1'b1;
      end else begin
        unique case (op_q)
          OP_TIGHT: begin
            if (rd_st != ST_UNLOCKED) begin
              wr_en = 1'b1;
              wr_st = ST_TIGHT;
            end
          end
          OP_LOCK: begin
            if (rd_st == ST_TIGHT) fin = 1'b1;
            else begin
              wr_en = 1'b1;
              wr_st = ST_LOCKED;
            end
          end
          default: begin
            if (rd_st == ST_TIGHT) fin = 1'b1;
            else begin
              wr_en = 1'b1;
              wr_st = ST_UNLOCKED;
            end
          end
        endcase
        if (cur_q == last_q) fin = 1'b1;
      end
    end
  end

  assign rd_idx = cur_q;
  assign wr_idx = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      op_q   <= OP_NONE;
      cur_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wp_q   <= ST_LOCKED;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q  <= W_RUN;
        op_q  <= op_in;
        err_q <= 1'b0;
        if (op_in == OP_UNLOCK_ALL) begin
          cur_q  <= '0;
          last_q <= LAST_IDX;
        end else begin
          cur_q  <= first_blk;
          last_q <= last_blk;
        end
      end else if (st_q == W_RUN) begin
        if (wr_en)   wp_q  <= wr_st;
        if (err_set) err_q <= 1'b1;
        if (fin) begin
          st_q   <= W_IDLE;
          done_q <= 1'b1;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  assign busy  = (st_q == W_RUN);
  assign done  = done_q;
  assign err   = err_q;
  assign wp_st = wp_q;

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == W_RUN));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_RUN) |=> $stable(op_q));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past({1'b0, cur_q} >= NB_EXT));

  // R9
  wp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wp_q));

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [IDX_W-1:0]  start_blk,
  output logic [IDX_W-1:0]  end_blk,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_code,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic [DATA_W-1:0] wp_status,
  input  logic [IDX_W-1:0]  qry_blk,
  output logic [2:0]        qry_state,
  output logic              qry_writable
);

  logic [IDX_W-1:0] rd_idx, wr_idx;
  blk_st_t          rd_st, wr_st, qry_st, wp_st;
  logic             wr_en;

  flk_range_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .start_o (start_blk),
    .end_o   (end_blk)
  );

  flk_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ready (cmd_ready),
    .first_blk (start_blk),
    .last_blk  (end_blk),
    .rd_idx    (rd_idx),
    .rd_st     (rd_st),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_st     (wr_st),
    .busy      (busy),
    .done      (done),
    .err       (cmd_err),
    .wp_st     (wp_st)
  );

  flk_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_st   (wr_st),
    .rd_idx  (rd_idx),
    .rd_st   (rd_st),
    .qry_idx (qry_blk),
    .qry_st  (qry_st)
  );

  assign wp_status    = {{(DATA_W-3){1'b0}}, wp_st};
  assign qry_state    = qry_st;
  assign qry_writable = (qry_st == ST_UNLOCKED);

  // R9
  wp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_status[DATA_W-1:3] == '0);

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

endmodule

// File: tb/sim_flash_lock_ctrl.sv
module sim_flash_lock_ctrl;

  localparam int NB = 12;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [IW-1:0] start_blk, end_blk;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [7:0]  cmd_code = '0;
  logic        busy, done, cmd_err;
  logic [15:0] wp_status;
  logic [IW-1:0] qry_blk = '0;
  logic [2:0]  qry_state;
  logic        qry_writable;

  always #4 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .start_blk(start_blk), .end_blk(end_blk),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .busy(busy), .done(done), .cmd_err(cmd_err), .wp_status(wp_status),
    .qry_blk(qry_blk), .qry_state(qry_state), .qry_writable(qry_writable)
  );

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [2:0]  m_st [NB];
  logic [15:0] m_wp;
  logic        m_err;
  int          m_cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model from the requirements: walk over the range, count visited blocks
  task automatic model_cmd(input logic [7:0] code, input int s, input int e);
    int first, last;
    m_cyc = 1;
    if (code != 8'h23 && code != 8'h27 && code != 8'h2a && code != 8'h2c) return;
    m_err = 1'b0;
    first = (code == 8'h27) ? 0 : s;
    last  = (code == 8'h27) ? NB - 1 : e;
    if (first > last) return;
    m_cyc = 0;
    for (int b = first; b <= last; b++) begin
      m_cyc++;
      if (b >= NB) begin m_err = 1'b1; return; end
      if (code == 8'h2c) begin
        if (m_st[b] != 3'b100) begin m_st[b] = 3'b001; m_wp = 16'h0001; end
      end else begin
        if (m_st[b] == 3'b001) return;
        m_st[b] = (code == 8'h2a) ? 3'b010 : 3'b100;
        m_wp = {13'd0, m_st[b]};
      end
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // offers a command, returns cycles from the accepting edge to done
  task automatic issue(input logic [7:0] code, output int cyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 64);
  endtask

  task automatic compare_blocks(input string req);
    for (int b = 0; b < NB; b++) begin
      qry_blk = IW'(b);
      #1;
      chk(qry_state == m_st[b], req, qry_state, m_st[b]);
      chk(qry_writable == (m_st[b] == 3'b100), "R2", qry_writable, m_st[b] == 3'b100);
    end
  endtask

  // {code, first, last} as raw register values
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'h23, 8'h02, 8'h05},   // unlock 2..5
    {8'h2c, 8'h04, 8'h07},   // tight: 4,5 skipped, 6,7 tight
    {8'h2a, 8'h00, 8'h09},   // lock 0..5, stops at 6
    {8'h27, 8'h00, 8'h00},   // unlock-all, stops at 6
    {8'h23, 8'h3a, 8'h1d},   // masked 10..13, error at 12
    {8'h2a, 8'h09, 8'h03},   // empty range
    {8'h55, 8'h00, 8'h0b},   // unknown code
    {8'h2c, 8'h08, 8'h08}    // single locked block to tight
  };

  initial begin : watchdog
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int cyc;
    for (int b = 0; b < NB; b++) m_st[b] = 3'b010;
    m_wp = 16'h0002; m_err = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wp_status == 16'h0002, "R1", wp_status, 16'h0002);
    chk(!busy && cmd_ready, "R1", {busy, cmd_ready}, 2'b01);
    chk(!cmd_err, "R1", cmd_err, 0);
    chk(start_blk == 0 && end_blk == 0, "R1", {start_blk, end_blk}, 0);
    compare_blocks("R1");

    // vector table: R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      logic [7:0] c, s, e;
      c = VEC[v][23:16]; s = VEC[v][15:8]; e = VEC[v][7:0];
      wr_reg(1'b0, {8'h00, s});
      wr_reg(1'b1, {8'h00, e});
      model_cmd(c, int'(s[IW-1:0]), int'(e[IW-1:0]));
      issue(c, cyc);
      chk(cyc == m_cyc, "R10 cycles", cyc, m_cyc);
      @(negedge clk);
      chk(!done, "R10 single pulse", done, 0);
      chk(cmd_err == m_err, "R8", cmd_err, m_err);
      chk(wp_status == m_wp, "R9", wp_status, m_wp);
      compare_blocks(c == 8'h27 ? "R7" : (c == 8'h2c ? "R6" : "R5"));
    end

    // R3 start write loads both, masked
    wr_reg(1'b0, 16'h0037);
    @(negedge clk);
    chk(start_blk == 4'd7 && end_blk == 4'd7, "R3", {start_blk, end_blk}, 8'h77);
    // R4 end write alone
    wr_reg(1'b1, 16'h0029);
    @(negedge clk);
    chk(start_blk == 4'd7, "R4", start_blk, 7);
    chk(end_blk == 4'd9, "R4", end_blk, 9);

    // R10 command offered while busy is ignored
    model_cmd(8'h27, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h27;
    @(negedge clk);
    cmd_code = 8'h2a;
    chk(busy && !cmd_ready, "R10 busy", {busy, cmd_ready}, 2'b10);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 64) begin @(negedge clk); cyc++; end
    chk(cyc == m_cyc, "R10 cycles", cyc, m_cyc);
    @(negedge clk);
    chk(cmd_ready && !busy, "R10 idle", {busy, cmd_ready}, 2'b01);
    compare_blocks("R10");
    chk(wp_status == m_wp, "R9", wp_status, m_wp);

    // R11 error flag cleared by an unknown code, nothing else changes
    wr_reg(1'b0, 16'h000e);
    model_cmd(8'h23, 14, 14);
    issue(8'h23, cyc);
    chk(cmd_err, "R8", cmd_err, 1);
    model_cmd(8'h00, 0, 0);
    issue(8'h00, cyc);
    chk(cyc == 1, "R11", cyc, 1);
    chk(!cmd_err, "R11", cmd_err, 0);
    chk(wp_status == m_wp, "R11", wp_status, m_wp);
    compare_blocks("R11");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule